// File: doc/BRIEF.md
# Single to Half Precision Narrowing Converter

This block narrows a 32-bit binary floating-point word (1 sign, 8 exponent, 23 fraction bits) to a 16-bit half-precision word (1 sign, 5 exponent, 10 fraction bits). It rounds to nearest with ties to even. It raises four exception flags: invalid, overflow, underflow and inexact. One operand is taken per cycle when `in_valid` is high. The result and its flags appear one clock later and are held until the next accepted operand.

Two mode inputs are sampled with each operand. `alt_fmt` selects an alternative half format that has no infinity or NaN encodings. In that format the all-ones exponent field holds ordinary normal numbers, and values out of range saturate. `dflt_nan` forces every NaN result to the canonical half NaN instead of carrying the input payload. Results below the half normal range are rounded to subnormals at a granularity of 2^-24, and may round up into the smallest normal.

Top module: `fp32_to_fp16_cvt`

## Requirements
- R1: A result and its flags appear on the outputs, with `out_valid` high, exactly one clock after an accepted operand. While `in_valid` is low, `out_valid` goes low and `out_half` and the flags keep their last values. After reset all outputs are zero.
- R2: For a finite input whose unbiased exponent lies in [-14, 15], the 13 discarded fraction bits are rounded to nearest, with ties going to the even result. A round-up carry may raise the exponent. Inexact is set exactly when a discarded bit is nonzero.
- R3: A finite input with unbiased exponent below -14 yields a subnormal, zero or smallest normal result, rounded to nearest even at a step of 2^-24. Underflow is set only when the rounded result has a zero exponent field and inexact is set.
- R4: An input whose exponent and fraction fields are both zero gives a zero of the same sign, with no flags. A nonzero input with a zero exponent field gives a zero of the same sign, with underflow and inexact set.
- R5: In IEEE mode, a finite input with unbiased exponent above 15 gives signed infinity (exponent field 5'h1F, fraction 0) with overflow and inexact set. So does a finite input that rounds up to exponent field 31.
- R6: In IEEE mode an infinite input gives an infinity of the same sign, with no flags.
- R7: In IEEE mode a NaN input gives {sign, 5'h1F, input fraction bits 22..13}. Invalid is set only for a signaling NaN, which is a NaN whose fraction bit 22 is zero.
- R8: In IEEE mode the result is the canonical NaN 16'h7E00 when `dflt_nan` is high, or when input fraction bits 22..13 are all zero. Invalid still follows R7.
- R9: In the alternative format a NaN input gives a zero of the same sign, whatever `dflt_nan` is. Invalid is set for a signaling NaN and no other flag is set.
- R10: In the alternative format an infinite input gives {sign, 15'h7FFF} with invalid set.
- R11: In the alternative format, exponent field 31 holds normal values up to 131008. A finite input above unbiased exponent 16, or one that rounds beyond that range, gives {sign, 15'h7FFF} with invalid and inexact set. Overflow is never set in this format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand accepted this cycle |
| in_word | input | 32 | Single-precision operand |
| alt_fmt | input | 1 | 1 selects the alternative half format without infinity/NaN |
| dflt_nan | input | 1 | 1 forces NaN results to the canonical NaN |
| out_valid | output | 1 | Result registered from the previous cycle's operand |
| out_half | output | 16 | Half-precision result |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Overflow (IEEE mode only) |
| flag_underflow | output | 1 | Tiny and inexact result |
| flag_inexact | output | 1 | Result differs from the input value |

## Verification
The normal-range rounding is tried with exact values, with ties whose kept LSB is even and with ties whose kept LSB is odd, with values just above a tie, and with an all-ones fraction that carries into the exponent. These patterns separate a correct ties-to-even rule from truncation, from rounding half away from zero, and from a lost carry. The subnormal path is tried at exact 2^-24, at ties at two different shift amounts, at a value below 2^-25 and at the value that rounds up into the smallest normal, which tells a correct variable shift and after-rounding tininess test apart from a fixed mask. The same large, infinite and NaN operands are sent in both format modes and with and without `dflt_nan`, so that a swapped mode path, a missing saturation or a wrong signaling test each change a compared word or flag.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  // Source (single) and destination (half) field widths
  localparam int SE = 8;
  localparam int SF = 23;
  localparam int DE = 5;
  localparam int DF = 10;

  localparam int SW    = 1 + SE + SF;
  localparam int DW    = 1 + DE + DF;
  localparam int SBIAS = (1 << (SE - 1)) - 1;
  localparam int DBIAS = (1 << (DE - 1)) - 1;
  localparam int SIGW  = SF + 1;            // significand with hidden bit
  localparam int DROP  = SF - DF;           // bits dropped in normal range
  localparam int EMIN_DST = 1 - DBIAS;      // smallest normal unbiased exponent
  localparam int EMAX_DST = DBIAS;          // largest IEEE unbiased exponent
  localparam int EMAX_ALT = DBIAS + 1;      // largest alternative-format exponent
  localparam int EMIN_SRC = 1 - SBIAS;      // exponent of source subnormals
  localparam int SHMAX = SIGW + 1;          // shift cap: everything below half an LSB
  localparam int SHW   = $clog2(SHMAX + 1);
  localparam int EW    = SE + 2;            // signed unbiased exponent width

  typedef enum logic [1:0] {
    CLS_FIN  = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } cls_e;

  // canonical half NaN: positive, quiet bit set, empty payload
  localparam logic [DW-1:0] CANON_NAN = {1'b0, {DE{1'b1}}, 1'b1, {(DF-1){1'b0}}};
  localparam logic [DW-2:0] MAG_SAT   = {(DW-1){1'b1}};
  localparam logic [DW-2:0] MAG_INF   = {{DE{1'b1}}, {DF{1'b0}}};
endpackage

// File: rtl/cvt_classify.sv
module cvt_classify
  import cvt_pkg::*;
(
  input  logic [SW-1:0]          word,
  output logic                   sign,
  output cls_e                   cls,
  output logic                   snan,
  output logic signed [EW-1:0]   uexp,
  output logic [SIGW-1:0]        sig,
  output logic [DF-1:0]          nan_pay
);
  localparam logic signed [EW-1:0] SBIAS_S    = EW'(SBIAS);
  localparam logic signed [EW-1:0] EMIN_SRC_S = EW'(EMIN_SRC);

  logic [SE-1:0] exp_f;
  logic [SF-1:0] frac_f;

  always_comb begin
    sign   = word[SW-1];
    exp_f  = word[SW-2:SF];
    frac_f = word[SF-1:0];

    if (&exp_f)
      cls = (frac_f != '0) ? CLS_NAN : CLS_INF;
    else if (exp_f == '0 && frac_f == '0)
      cls = CLS_ZERO;
    else
      cls = CLS_FIN;

    snan    = (cls == CLS_NAN) && !frac_f[SF-1];
    uexp    = (exp_f == '0) ? EMIN_SRC_S : ($signed(EW'(exp_f)) - SBIAS_S);
    sig     = {exp_f != '0, frac_f};
    nan_pay = frac_f[SF-1 -: DF];
  end
endmodule

// File: rtl/cvt_round.sv
module cvt_round
  import cvt_pkg::*;
(
  input  logic signed [EW-1:0] uexp,
  input  logic [SIGW-1:0]      sig,
  input  logic                 alt_fmt,
  output logic [DW-2:0]        mag,
  output logic                 inexact,
  output logic                 range_ovf,
  output logic                 tiny
);
  localparam int WW = SHMAX + DF;
  localparam logic signed [EW-1:0] EMIN_S  = EW'(EMIN_DST);
  localparam logic signed [EW-1:0] EMAX_S  = EW'(EMAX_DST);
  localparam logic signed [EW-1:0] EALT_S  = EW'(EMAX_ALT);
  localparam logic signed [EW-1:0] BIAS_S  = EW'(DBIAS);
  localparam logic signed [EW-1:0] SHMAX_S = EW'(SHMAX);
  localparam logic signed [EW-1:0] ONE_S   = EW'(1);

  logic signed [EW-1:0] need_sh;
  logic [SHW-1:0]       sh;
  logic [WW-1:0]        wide;
  logic [DE-1:0]        he;
  logic                 guard, sticky, rup, big;
  logic [DE+DF:0]       sum;

  always_comb begin
    big = uexp > (alt_fmt ? EALT_S : EMAX_S);

    // variable discard width: fixed in normal range, growing below it
    need_sh = -uexp - ONE_S;
    if (uexp < EMIN_S) begin
      sh = (need_sh > SHMAX_S) ? SHW'(SHMAX) : SHW'(need_sh);
      he = '0;
    end else begin
      sh = SHW'(DROP);
      he = DE'(uexp + BIAS_S);
    end

    wide   = WW'({sig, {SHMAX{1'b0}}} >> sh);
    guard  = wide[SHMAX-1];
    sticky = |wide[SHMAX-2:0];
    rup    = guard & (sticky | wide[SHMAX]);

    // carry out of the fraction field bumps the exponent field
    sum = {1'b0, he, wide[SHMAX +: DF]} + (DE+DF+1)'(rup);

    mag       = sum[DE+DF-1:0];
    inexact   = guard | sticky | big;
    range_ovf = big | (alt_fmt ? sum[DE+DF] : (&sum[DE+DF-1:DF]));
    tiny      = ~|sum[DE+DF-1:DF];
  end
endmodule

// File: rtl/cvt_select.sv
module cvt_select
  import cvt_pkg::*;
(
  input  logic            sign,
  input  cls_e            cls,
  input  logic            snan,
  input  logic [DF-1:0]   nan_pay,
  input  logic            alt_fmt,
  input  logic            dflt_nan,
  input  logic [DW-2:0]   mag,
  input  logic            inexact,
  input  logic            range_ovf,
  input  logic            tiny,
  output logic [DW-1:0]   result,
  output logic [3:0]      flags    // {invalid, overflow, underflow, inexact}
);
  always_comb begin
    result = {sign, {(DW-1){1'b0}}};
    flags  = 4'b0000;
    unique case (cls)
      CLS_NAN: begin
        flags[3] = snan;
        if (alt_fmt)
          result = {sign, {(DW-1){1'b0}}};
        else if (dflt_nan || nan_pay == '0)
          result = CANON_NAN;
        else
          result = {sign, {DE{1'b1}}, nan_pay};
      end
      CLS_INF: begin
        if (alt_fmt) begin
          result   = {sign, MAG_SAT};
          flags[3] = 1'b1;
        end else begin
          result = {sign, MAG_INF};
        end
      end
      CLS_ZERO: result = {sign, {(DW-1){1'b0}}};
      default: begin
        if (range_ovf) begin
          if (alt_fmt) begin
            result = {sign, MAG_SAT};
            flags  = 4'b1001;
          end else begin
            result = {sign, MAG_INF};
            flags  = 4'b0101;
          end
        end else begin
          result   = {sign, mag};
          flags[0] = inexact;
          flags[1] = inexact & tiny;
        end
      end
    endcase
  end
endmodule

// File: rtl/fp32_to_fp16_cvt.sv
module fp32_to_fp16_cvt
  import cvt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] in_word,
  input  logic          alt_fmt,
  input  logic          dflt_nan,
  output logic          out_valid,
  output logic [DW-1:0] out_half,
  output logic          flag_invalid,
  output logic          flag_overflow,
  output logic          flag_underflow,
  output logic          flag_inexact
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                  c_sign, c_snan, r_inexact, r_ovf, r_tiny;
  cls_e                  c_cls;
  logic signed [EW-1:0]  c_uexp;
  logic [SIGW-1:0]       c_sig;
  logic [DF-1:0]         c_pay;
  logic [DW-2:0]         r_mag;
  logic [DW-1:0]         s_result;
  logic [3:0]            s_flags;

  cvt_classify u_cls (
    .word(in_word), .sign(c_sign), .cls(c_cls), .snan(c_snan),
    .uexp(c_uexp), .sig(c_sig), .nan_pay(c_pay)
  );

  cvt_round u_rnd (
    .uexp(c_uexp), .sig(c_sig), .alt_fmt(alt_fmt), .mag(r_mag),
    .inexact(r_inexact), .range_ovf(r_ovf), .tiny(r_tiny)
  );

  cvt_select u_sel (
    .sign(c_sign), .cls(c_cls), .snan(c_snan), .nan_pay(c_pay),
    .alt_fmt(alt_fmt), .dflt_nan(dflt_nan), .mag(r_mag),
    .inexact(r_inexact), .range_ovf(r_ovf), .tiny(r_tiny),
    .result(s_result), .flags(s_flags)
  );

  logic          valid_q, valid_d;
  logic [DW-1:0] half_q, half_d;
  logic [3:0]    flags_q, flags_d;

  always_comb begin
    valid_d = in_valid;
    half_d  = half_q;
    flags_d = flags_q;
    if (in_valid) begin
      half_d  = s_result;
      flags_d = s_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      half_q  <= '0;
      flags_q <= 4'b0000;
    end else begin
      valid_q <= valid_d;
      half_q  <= half_d;
      flags_q <= flags_d;
    end
  end

  assign out_valid      = valid_q;
  assign out_half       = half_q;
  assign flag_invalid   = flags_q[3];
  assign flag_overflow  = flags_q[2];
  assign flag_underflow = flags_q[1];
  assign flag_inexact   = flags_q[0];

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> (!out_valid && $stable(out_half) && $stable(flags_q)));
  // R5
  ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && flag_overflow) |-> (flag_inexact && out_half[DW-2:0] == MAG_INF));
  // R3
  uf_tiny_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && flag_underflow) |-> (flag_inexact && out_half[DW-2:DF] == '0));
  // R11
  alt_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && alt_fmt) |=> !flag_overflow);
  // R4
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && in_word[SW-2:0] == '0) |=>
      (out_half == {$past(in_word[SW-1]), {(DW-1){1'b0}}} && !flag_inexact));
  // R8
  dnan_canon_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !alt_fmt && dflt_nan && (&in_word[SW-2:SF]) && (in_word[SF-1:0] != '0))
      |=> (out_half == CANON_NAN));
endmodule

// File: tb/fp32_to_fp16_cvt_tb.sv
module fp32_to_fp16_cvt_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        alt_fmt, dflt_nan;
  logic        out_valid;
  logic [15:0] out_half;
  logic        flag_invalid, flag_overflow, flag_underflow, flag_inexact;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_to_fp16_cvt dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .alt_fmt(alt_fmt), .dflt_nan(dflt_nan), .out_valid(out_valid),
    .out_half(out_half), .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
    .flag_underflow(flag_underflow), .flag_inexact(flag_inexact)
  );

  typedef struct {
    logic [15:0] half;
    logic [3:0]  fl;    // {invalid, overflow, underflow, inexact}
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic        mon_on = 1'b0;
  logic        have_last = 1'b0;
  logic        done = 1'b0;
  logic [15:0] last_half;
  logic [3:0]  last_fl;

  function automatic logic [3:0] cur_fl();
    return {flag_invalid, flag_overflow, flag_underflow, flag_inexact};
  endfunction

  task automatic compare(input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual half=%h flags=%b expected half=%h flags=%b",
               tag, act[19:4], act[3:0], exp[19:4], exp[3:0]);
    end
  endtask

  // driver: called at a falling edge
  task automatic send(input logic [31:0] w, input logic alt, input logic dn,
                      input logic [15:0] eh, input logic [3:0] ef,
                      input string tag, input int gap);
    item_t it;
    it.half = eh; it.fl = ef; it.tag = tag;
    in_word  = w;
    alt_fmt  = alt;
    dflt_nan = dn;
    in_valid = 1'b1;
    sb_q.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R1 spurious result: actual half=%h expected no result", out_half);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          compare(it.tag, {out_half, cur_fl()}, {it.half, it.fl});
        end
        last_half = out_half;
        last_fl   = cur_fl();
        have_last = 1'b1;
      end else if (have_last) begin
        compare("R1 hold while idle", {out_half, cur_fl()}, {last_half, last_fl});
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; alt_fmt = 1'b0; dflt_nan = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_cmp++;
    if ({out_valid, out_half, cur_fl()} !== 21'd0) begin
      n_bad++;
      $display("FAIL R1 reset state: actual valid=%b half=%h flags=%b expected 0/0000/0000",
               out_valid, out_half, cur_fl());
    end
    mon_on = 1'b1;

    // R2 normal range rounding
    send(32'h3F800000, 0, 0, 16'h3C00, 4'b0000, "R2 one exact", 0);
    send(32'hC0200000, 0, 0, 16'hC100, 4'b0000, "R2 neg 2.5", 1);
    send(32'h3F801000, 0, 0, 16'h3C00, 4'b0001, "R2 tie to even down", 0);
    send(32'h3F803000, 0, 0, 16'h3C02, 4'b0001, "R2 tie to even up", 0);
    send(32'h3F801001, 0, 0, 16'h3C01, 4'b0001, "R2 above half", 2);
    send(32'h3FFFFFFF, 0, 0, 16'h4000, 4'b0001, "R2 carry into exponent", 0);
    send(32'h477FE000, 0, 0, 16'h7BFF, 4'b0000, "R2 largest half", 0);
    send(32'h38800000, 0, 0, 16'h0400, 4'b0000, "R2 smallest normal", 0);
    // R5 IEEE overflow
    send(32'h477FF000, 0, 0, 16'h7C00, 4'b0101, "R5 round to infinity", 0);
    send(32'h501502F9, 0, 0, 16'h7C00, 4'b0101, "R5 large value", 0);
    send(32'h47800000, 0, 0, 16'h7C00, 4'b0101, "R5 two to sixteen", 1);
    // R3 subnormal results
    send(32'h33800000, 0, 0, 16'h0001, 4'b0000, "R3 exact 2^-24", 0);
    send(32'h33000000, 0, 0, 16'h0000, 4'b0011, "R3 tie 2^-25 to zero", 0);
    send(32'h33400000, 0, 0, 16'h0001, 4'b0011, "R3 above half lsb", 0);
    send(32'h33C00000, 0, 0, 16'h0002, 4'b0011, "R3 tie odd rounds up", 0);
    send(32'h34200000, 0, 0, 16'h0002, 4'b0011, "R3 tie even stays", 0);
    send(32'h387FFFFF, 0, 0, 16'h0400, 4'b0001, "R3 rounds into normal", 0);
    send(32'hB8400000, 0, 0, 16'h8300, 4'b0000, "R3 exact negative subnormal", 0);
    send(32'h2EDBE6FF, 0, 0, 16'h0000, 4'b0011, "R3 far below range", 0);
    // R4 zeros and source subnormals
    send(32'h80000000, 0, 0, 16'h8000, 4'b0000, "R4 negative zero", 0);
    send(32'h00000000, 1, 0, 16'h0000, 4'b0000, "R4 positive zero alt", 0);
    send(32'h80000001, 0, 0, 16'h8000, 4'b0011, "R4 source subnormal", 0);
    // R6 infinities
    send(32'h7F800000, 0, 0, 16'h7C00, 4'b0000, "R6 plus infinity", 0);
    send(32'hFF800000, 0, 0, 16'hFC00, 4'b0000, "R6 minus infinity", 0);
    // R7 NaN narrowing
    send(32'hFFC02000, 0, 0, 16'hFE01, 4'b0000, "R7 quiet payload", 0);
    send(32'h7F802000, 0, 0, 16'h7C01, 4'b1000, "R7 signaling payload", 0);
    // R8 canonical NaN
    send(32'h7F800001, 0, 0, 16'h7E00, 4'b1000, "R8 empty narrowed payload", 0);
    send(32'hFFC02000, 0, 1, 16'h7E00, 4'b0000, "R8 dflt_nan quiet", 0);
    send(32'hFF802000, 0, 1, 16'h7E00, 4'b1000, "R8 dflt_nan signaling", 1);
    // R9 alternative NaN
    send(32'hFF800001, 1, 0, 16'h8000, 4'b1000, "R9 signaling to zero", 0);
    send(32'h7FC00000, 1, 0, 16'h0000, 4'b0000, "R9 quiet to zero", 0);
    send(32'hFFC00000, 1, 1, 16'h8000, 4'b0000, "R9 dflt_nan ignored", 0);
    // R10 alternative infinity
    send(32'hFF800000, 1, 0, 16'hFFFF, 4'b1000, "R10 minus infinity saturates", 0);
    send(32'h7F800000, 1, 0, 16'h7FFF, 4'b1000, "R10 plus infinity saturates", 0);
    // R11 alternative range
    send(32'h47800000, 1, 0, 16'h7C00, 4'b0000, "R11 two to sixteen normal", 0);
    send(32'h47FFE000, 1, 0, 16'h7FFF, 4'b0000, "R11 largest alt value", 0);
    send(32'h47FFF000, 1, 0, 16'h7FFF, 4'b1001, "R11 rounds past range", 0);
    send(32'h48000000, 1, 0, 16'h7FFF, 4'b1001, "R11 exponent 17", 0);
    send(32'hD01502F9, 1, 0, 16'hFFFF, 4'b1001, "R11 negative large", 0);
    send(32'h3F803000, 1, 0, 16'h3C02, 4'b0001, "R2 rounding in alt", 0);
    send(32'h33000000, 1, 0, 16'h0000, 4'b0011, "R3 tiny in alt", 3);

    repeat (3) @(negedge clk);
    n_cmp++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 missing results: actual %0d pending expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog expired: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule